// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block drives the two configuration words of an external PLL and walks it through a safe divider change. A request carries a reference divider, a feedback divider, two post-dividers, a 24-bit fraction and a fractional-mode flag. If the requested setting is already in place, the request finishes without touching the PLL. Otherwise the block raises the PLL reset, loads the new dividers (and the fraction in fractional mode), keeps reset high for a fixed hold time, releases it, waits for lock with a time limit, and then waits a settle time before reporting completion.

Besides reprogramming, the block takes three smaller requests. Init clears bypass and sets the two power-down controls to suit the mode. Prepare brings the PLL out of reset if it is held there. Unprepare puts it back into reset. All delays are whole microseconds, counted in clock cycles through a cycles-per-microsecond parameter.

Top module: `pll_reprog_seq`

## Requirements
- R1: After synchronous reset, `div_word` is 0, `ctl_word` is 0x6300_0000 (bypass bit 30, PLL reset bit 29, DAC power-down bit 25 and sigma-delta power-down bit 24 all set), and `busy`, `done` and `timeout` are 0.
- R2: An init request clears bit 30 and sets bits 24 and 25 when `frac_mode` is 0, or clears both when it is 1. All other bits are unchanged. `done` pulses on the cycle after the accepting edge.
- R3: A reprogram loads `div_word` on the accepting edge with the reference divider in bits 5:0, the feedback divider in bits 19:8, post-divider 1 in bits 22:20 and post-divider 2 in bits 26:24, with every other bit 0. Bit 29 of `ctl_word` is set on that same edge.
- R4: A reprogram writes the fraction into `ctl_word[23:0]` only when `frac_mode` is 1. In integer mode that field keeps its old value.
- R5: A start whose four dividers equal those in `div_word`, and whose fraction equals `ctl_word[23:0]` when in fractional mode, changes neither word, never raises `busy`, and pulses `done` on the cycle after the accepting edge.
- R6: During a reprogram, bit 29 of `ctl_word` stays high for exactly HOLD_US*CYC_PER_US cycles and is then cleared.
- R7: If `pll_lock` is not seen within LOCK_TMO_US*CYC_PER_US cycles after reset release, `timeout` pulses on that edge, `busy` falls, and bit 29 stays low.
- R8: Once `pll_lock` is sampled high after release, `done` pulses SETTLE_US*CYC_PER_US cycles later and `busy` falls.
- R9: Prepare with bit 29 low pulses `done` on the next cycle. With bit 29 high it runs the hold, lock-wait and settle steps without changing `div_word`.
- R10: Unprepare sets bit 29, leaves every other bit of both words unchanged, and pulses `done` on the next cycle.
- R11: Requests that arrive while `busy` is 1 are ignored.
- R12: `done` and `timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Reprogram request |
| prep_req | input | 1 | Prepare (leave reset) request |
| unprep_req | input | 1 | Unprepare (enter reset) request |
| init_req | input | 1 | Initial control-bit setup request |
| frac_mode | input | 1 | 1 selects fractional mode |
| ref_div | input | 6 | Requested reference divider |
| fb_div | input | 12 | Requested feedback divider |
| post_div1 | input | 3 | Requested first post-divider |
| post_div2 | input | 3 | Requested second post-divider |
| frac_val | input | 24 | Requested fraction |
| pll_lock | input | 1 | Lock status from the PLL |
| div_word | output | 32 | Divider configuration word |
| ctl_word | output | 32 | Fraction and control word |
| busy | output | 1 | A multi-cycle sequence is running |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle lock-timeout pulse |

## Verification
Every result has a due cycle measured from the accepting edge `a`:
- Skipped reprogram, init, unprepare, and prepare with reset already low: `done` is due in the cycle after `a`.
- Reset release: due at `a + hold`.
- Timeout: due at `a + hold + limit`.
- Lock model: raises lock a fixed latency after it sees reset low, so a full reprogram completes at `a + hold + latency + 1 + settle`.

The driver computes each due cycle when it issues the request and queues it. The monitor samples on the falling edge and compares the cycle number of every pulse it sees with the head of the queue. Word contents and the reset bit are sampled at the accepting cycle and on both sides of the release edge.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int WORD_W      = 32;
    localparam int REF_W       = 6;
    localparam int FB_W        = 12;
    localparam int PDIV_W      = 3;
    localparam int FRAC_W      = 24;

    // field placement decoded by the PLL macro
    localparam int REF_LSB     = 0;
    localparam int FB_LSB      = 8;
    localparam int PD1_LSB     = 20;
    localparam int PD2_LSB     = 24;
    localparam int SDM_PD_BIT  = 24;
    localparam int DAC_PD_BIT  = 25;
    localparam int PLL_RST_BIT = 29;
    localparam int BYPASS_BIT  = 30;

    localparam logic [WORD_W-1:0] CTL_RESET_VAL =
        (32'd1 << BYPASS_BIT) | (32'd1 << PLL_RST_BIT) |
        (32'd1 << DAC_PD_BIT) | (32'd1 << SDM_PD_BIT);

    typedef struct packed {
        logic [REF_W-1:0]  ref_div;
        logic [FB_W-1:0]   fb_div;
        logic [PDIV_W-1:0] pdiv1;
        logic [PDIV_W-1:0] pdiv2;
        logic [FRAC_W-1:0] frac;
    } div_set_t;

    typedef enum logic [2:0] {
        CFG_NONE,
        CFG_PROGRAM,
        CFG_RST_SET,
        CFG_RST_CLR,
        CFG_INIT
    } cfg_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_LOCK,
        SQ_SETTLE
    } seq_state_e;

    function automatic logic [WORD_W-1:0] pack_div(div_set_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[REF_LSB +: REF_W]  = s.ref_div;
        w[FB_LSB  +: FB_W]   = s.fb_div;
        w[PD1_LSB +: PDIV_W] = s.pdiv1;
        w[PD2_LSB +: PDIV_W] = s.pdiv2;
        return w;
    endfunction

    function automatic logic same_setting(div_set_t s, logic [WORD_W-1:0] dw,
                                          logic [WORD_W-1:0] cw, logic fmode);
        logic eq;
        eq = (pack_div(s) == dw);
        if (fmode)
            eq = eq && (s.frac == cw[FRAC_W-1:0]);
        return eq;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pll_dly_timer.sv
module pll_dly_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // the sequencer never counts below zero
    AST_TMR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |-> !zero); // R7

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_op_e           op,
    input  div_set_t          req,
    input  logic              frac_mode,
    output logic [WORD_W-1:0] div_word,
    output logic [WORD_W-1:0] ctl_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            div_word <= '0;
            ctl_word <= CTL_RESET_VAL;
        end else begin
            unique case (op)
                CFG_PROGRAM: begin
                    div_word              <= pack_div(req);
                    ctl_word[PLL_RST_BIT] <= 1'b1;
                    if (frac_mode)
                        ctl_word[FRAC_W-1:0] <= req.frac;
                end
                CFG_RST_SET: ctl_word[PLL_RST_BIT] <= 1'b1;
                CFG_RST_CLR: ctl_word[PLL_RST_BIT] <= 1'b0;
                CFG_INIT: begin
                    ctl_word[BYPASS_BIT] <= 1'b0;
                    ctl_word[SDM_PD_BIT] <= !frac_mode;
                    ctl_word[DAC_PD_BIT] <= !frac_mode;
                end
                default: ;
            endcase
        end
    end

    AST_INT_FRAC_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op == CFG_PROGRAM && !frac_mode) |=> $stable(ctl_word[FRAC_W-1:0])); // R4

    AST_UNPREP_DIV_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op == CFG_RST_SET) |=> ($stable(div_word) && ctl_word[PLL_RST_BIT])); // R10

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int HOLD_CYC   = 3,
    parameter int LOCK_CYC   = 100,
    parameter int SETTLE_CYC = 30,
    parameter int CW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          prep_req,
    input  logic          unprep_req,
    input  logic          init_req,
    input  logic          unchanged,
    input  logic          pll_rst_on,
    input  logic          pll_lock,
    input  logic          tmr_zero,
    output cfg_op_e       cfg_op,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          tmr_dec,
    output seq_state_e    state,
    output logic          busy,
    output logic          done,
    output logic          timeout
);
    localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LOCK_LD   = CW'(LOCK_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);

    seq_state_e nxt;
    logic       done_nxt;
    logic       tmo_nxt;

    always_comb begin
        nxt      = state;
        cfg_op   = CFG_NONE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        done_nxt = 1'b0;
        tmo_nxt  = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (start) begin
                    if (unchanged) begin
                        done_nxt = 1'b1;
                    end else begin
                        cfg_op   = CFG_PROGRAM;
                        tmr_load = 1'b1;
                        tmr_val  = HOLD_LD;
                        nxt      = SQ_HOLD;
                    end
                end else if (prep_req) begin
                    if (!pll_rst_on) begin
                        done_nxt = 1'b1;
                    end else begin
                        cfg_op   = CFG_RST_SET;
                        tmr_load = 1'b1;
                        tmr_val  = HOLD_LD;
                        nxt      = SQ_HOLD;
                    end
                end else if (unprep_req) begin
                    cfg_op   = CFG_RST_SET;
                    done_nxt = 1'b1;
                end else if (init_req) begin
                    cfg_op   = CFG_INIT;
                    done_nxt = 1'b1;
                end
            end
            SQ_HOLD: begin
                if (tmr_zero) begin
                    cfg_op   = CFG_RST_CLR;
                    tmr_load = 1'b1;
                    tmr_val  = LOCK_LD;
                    nxt      = SQ_LOCK;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            SQ_LOCK: begin
                if (pll_lock) begin
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                    nxt      = SQ_SETTLE;
                end else if (tmr_zero) begin
                    tmo_nxt = 1'b1;
                    nxt     = SQ_IDLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            SQ_SETTLE: begin
                if (tmr_zero) begin
                    done_nxt = 1'b1;
                    nxt      = SQ_IDLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            state   <= nxt;
            done    <= done_nxt;
            timeout <= tmo_nxt;
        end
    end

    assign busy = (state != SQ_IDLE);

    AST_SKIP_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && start && unchanged) |=> (done && !busy)); // R5

    AST_PREP_LOW_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && !start && prep_req && !pll_rst_on) |=> (done && !busy)); // R9

    AST_DONE_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout)); // R12

    AST_SETTLE_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_LOCK && pll_lock) |=> (state == SQ_SETTLE)); // R8

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int CYC_PER_US  = 250,
    parameter int HOLD_US     = 3,
    parameter int SETTLE_US   = 30,
    parameter int LOCK_TMO_US = 10000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        prep_req,
    input  logic        unprep_req,
    input  logic        init_req,
    input  logic        frac_mode,
    input  logic [5:0]  ref_div,
    input  logic [11:0] fb_div,
    input  logic [2:0]  post_div1,
    input  logic [2:0]  post_div2,
    input  logic [23:0] frac_val,
    input  logic        pll_lock,
    output logic [31:0] div_word,
    output logic [31:0] ctl_word,
    output logic        busy,
    output logic        done,
    output logic        timeout
);
    localparam int HOLD_CYC   = HOLD_US * CYC_PER_US;
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int LOCK_CYC   = LOCK_TMO_US * CYC_PER_US;
    localparam int MAX_CYC    = max3(HOLD_CYC, SETTLE_CYC, LOCK_CYC);
    localparam int CW         = $clog2(MAX_CYC + 1);

    div_set_t   req;
    cfg_op_e    cfg_op;
    seq_state_e state;
    logic       unchanged;
    logic       tmr_load;
    logic       tmr_dec;
    logic       tmr_zero;
    logic [CW-1:0] tmr_val;

    always_comb begin
        req.ref_div = ref_div;
        req.fb_div  = fb_div;
        req.pdiv1   = post_div1;
        req.pdiv2   = post_div2;
        req.frac    = frac_val;
    end

    assign unchanged = same_setting(req, div_word, ctl_word, frac_mode);

    pll_seq_ctrl #(
        .HOLD_CYC   (HOLD_CYC),
        .LOCK_CYC   (LOCK_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .CW         (CW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .prep_req   (prep_req),
        .unprep_req (unprep_req),
        .init_req   (init_req),
        .unchanged  (unchanged),
        .pll_rst_on (ctl_word[PLL_RST_BIT]),
        .pll_lock   (pll_lock),
        .tmr_zero   (tmr_zero),
        .cfg_op     (cfg_op),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .tmr_dec    (tmr_dec),
        .state      (state),
        .busy       (busy),
        .done       (done),
        .timeout    (timeout)
    );

    pll_dly_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    pll_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .op        (cfg_op),
        .req       (req),
        .frac_mode (frac_mode),
        .div_word  (div_word),
        .ctl_word  (ctl_word)
    );

    AST_PROG_UNDER_RST: assert property (@(posedge clk) disable iff (rst)
        $changed(div_word) |-> ctl_word[PLL_RST_BIT]); // R3

    AST_BUSY_DIV_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(div_word)); // R11

    AST_HOLD_RST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_HOLD) |-> ctl_word[PLL_RST_BIT]); // R6

    AST_TMO_RST_LOW: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (!ctl_word[PLL_RST_BIT] && !busy)); // R7

endmodule

// File: tb/tb_pll_reprog_seq.sv
`timescale 1ns/100ps
module tb_pll_reprog_seq;
    localparam int CPU  = 2;
    localparam int HUS  = 3;
    localparam int SUS  = 30;
    localparam int TUS  = 40;
    localparam int NH   = HUS * CPU;
    localparam int NS   = SUS * CPU;
    localparam int NT   = TUS * CPU;
    localparam int LAT  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, prep_req = 0, unprep_req = 0, init_req = 0, frac_mode = 0;
    logic [5:0]  ref_div = 0;
    logic [11:0] fb_div = 0;
    logic [2:0]  post_div1 = 0, post_div2 = 0;
    logic [23:0] frac_val = 0;
    logic        pll_lock;
    logic [31:0] div_word, ctl_word;
    logic        busy, done, timeout;

    pll_reprog_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS), .SETTLE_US(SUS),
                     .LOCK_TMO_US(TUS)) dut (.*);

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // PLL lock model: lock rises LAT cycles after reset is seen low
    logic lock_block = 0;
    int   lcnt = 0;
    logic lock_q = 0;
    always @(posedge clk) begin
        if (rst || ctl_word[29] || lock_block) begin
            lcnt   <= 0;
            lock_q <= 1'b0;
        end else if (lcnt == LAT - 1) begin
            lock_q <= 1'b1;
        end else begin
            lcnt <= lcnt + 1;
        end
    end
    assign pll_lock = lock_q;

    int n_chk = 0, n_bad = 0;

    typedef struct { bit is_tmo; int due; string tag; } exp_t;
    exp_t sb[$];

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // monitor: compare each pulse against the scoreboard head
    logic prev_done = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done && timeout)
                chk(0, "R12 done+timeout", {done, timeout}, 32'd0);
            if (done && prev_done)
                chk(0, "R12 done width", 32'd2, 32'd1);
            if (done || timeout) begin
                if (sb.size() == 0) begin
                    chk(0, "R11 unexpected pulse", cyc, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.is_tmo == timeout && e.due == cyc, e.tag, cyc, e.due);
                end
            end
            prev_done <= done;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [31:0] dword(int r, int f, int p1, int p2);
        return (32'(p2) << 24) | (32'(p1) << 20) | (32'(f) << 8) | 32'(r);
    endfunction

    task automatic set_req(int r, int f, int p1, int p2, int fr);
        ref_div = 6'(r); fb_div = 12'(f); post_div1 = 3'(p1); post_div2 = 3'(p2);
        frac_val = 24'(fr);
    endtask

    // kind: 0 start, 1 prepare, 2 unprepare, 3 init; delay = due offset, -1 none
    task automatic fire(int kind, int delay, bit is_tmo, string tag, output int a);
        exp_t e;
        a = cyc + 1;
        if (delay >= 0) begin
            e.is_tmo = is_tmo; e.due = a + delay; e.tag = tag;
            sb.push_back(e);
        end
        case (kind)
            0: start = 1;
            1: prep_req = 1;
            2: unprep_req = 1;
            default: init_req = 1;
        endcase
        tick();
        start = 0; prep_req = 0; unprep_req = 0; init_req = 0;
    endtask

    task automatic drain();
        while (sb.size() != 0) tick();
        tick();
    endtask

    task automatic hold_check(int a, string tag);
        while (cyc < a + NH - 1) tick();
        chk(ctl_word[29] === 1'b1 && busy, tag, ctl_word, 32'h2000_0000);
        tick();
        chk(ctl_word[29] === 1'b0, tag, ctl_word, 32'h0);
    endtask

    localparam int FULL = NH + LAT + 1 + NS;

    initial begin
        int a;
        repeat (5) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(div_word == 0, "R1 div_word", div_word, 0);
        chk(ctl_word == 32'h6300_0000, "R1 ctl_word", ctl_word, 32'h6300_0000);
        chk(!busy && !done && !timeout, "R1 flags", {busy, done, timeout}, 0);

        // R2 init, integer mode
        frac_mode = 0;
        fire(3, 0, 0, "R2 init done", a);
        chk(ctl_word == 32'h2300_0000, "R2 init int", ctl_word, 32'h2300_0000);

        // R3 R4 R6 R8 integer reprogram
        set_req(3, 100, 2, 1, 24'hABCDEF);
        fire(0, FULL, 0, "R8 settle done", a);
        chk(div_word == dword(3, 100, 2, 1), "R3 div layout", div_word, dword(3, 100, 2, 1));
        chk(ctl_word == 32'h2300_0000, "R4 int frac untouched", ctl_word, 32'h2300_0000);
        hold_check(a, "R6 hold");
        drain();
        chk(ctl_word == 32'h0300_0000 && !busy, "R8 after done", ctl_word, 32'h0300_0000);

        // R5 unchanged dividers, fraction differs but integer mode
        set_req(3, 100, 2, 1, 24'h000111);
        fire(0, 0, 0, "R5 skip int", a);
        chk(!busy && div_word == dword(3, 100, 2, 1), "R5 no busy", {busy, div_word[30:0]}, dword(3, 100, 2, 1));
        chk(ctl_word == 32'h0300_0000, "R5 ctl kept", ctl_word, 32'h0300_0000);
        drain();

        // R11 new request while busy ignored
        set_req(1, 200, 1, 1, 0);
        fire(0, FULL, 0, "R11 single done", a);
        tick(); tick();
        set_req(2, 50, 4, 2, 0);
        start = 1; tick(); start = 0;
        prep_req = 1; tick(); prep_req = 0;
        set_req(1, 200, 1, 1, 0);
        drain();
        repeat (4) tick();
        chk(div_word == dword(1, 200, 1, 1), "R11 div kept", div_word, dword(1, 200, 1, 1));

        // R2 init, fractional mode
        frac_mode = 1;
        fire(3, 0, 0, "R2 init frac done", a);
        chk(ctl_word == 32'h0000_0000, "R2 init frac", ctl_word, 32'h0);

        // R4 R5 fraction change alone triggers reprogram
        set_req(1, 200, 1, 1, 24'h123456);
        fire(0, FULL, 0, "R5 frac change done", a);
        chk(ctl_word == 32'h2012_3456, "R4 frac written", ctl_word, 32'h2012_3456);
        drain();
        chk(ctl_word == 32'h0012_3456, "R4 frac after", ctl_word, 32'h0012_3456);

        // R5 all equal in fractional mode
        fire(0, 0, 0, "R5 skip frac", a);
        chk(!busy, "R5 frac skip busy", busy, 0);

        // R7 lock timeout, max divider values
        lock_block = 1;
        set_req(63, 4095, 7, 7, 24'h123456);
        fire(0, NH + NT, 1, "R7 timeout", a);
        drain();
        chk(!busy && ctl_word == 32'h0012_3456, "R7 after timeout", ctl_word, 32'h0012_3456);
        chk(div_word == dword(63, 4095, 7, 7), "R3 max fields", div_word, dword(63, 4095, 7, 7));
        lock_block = 0;

        // R10 unprepare
        fire(2, 0, 0, "R10 done", a);
        chk(ctl_word == 32'h2012_3456, "R10 ctl", ctl_word, 32'h2012_3456);
        chk(div_word == dword(63, 4095, 7, 7), "R10 div kept", div_word, dword(63, 4095, 7, 7));

        // R9 prepare from reset, then with reset low
        fire(1, FULL, 0, "R9 prepare seq", a);
        hold_check(a, "R9 hold");
        drain();
        chk(ctl_word == 32'h0012_3456 && div_word == dword(63, 4095, 7, 7),
            "R9 after prepare", ctl_word, 32'h0012_3456);
        fire(1, 0, 0, "R9 prepare noop", a);
        chk(!busy, "R9 noop busy", busy, 0);
        drain();

        repeat (5) tick();
        chk(sb.size() == 0, "R12 pending", sb.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule